// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the serial clock for an I2C master. SCL is driven low and then released high in turn, and two 8-bit width registers set the length of each phase in base clock cycles. During every low phase the block also raises a one-cycle SDA update strobe. The strobe comes a fixed fraction of the low width after the falling edge, and this delay sets the data hold time.

A surrounding protocol controller sets the enable, programs the widths while the enable is low, and raises a run request to start clocking. It drops the request to stop, and clocking then ends after the current high phase. The block reads the SCL line back through a sense input. The high phase only counts cycles in which the line really reads high, so a slave that holds SCL low stretches the clock.

Top module: `scl_timing_gen`

## Requirements
- R1: After a synchronous reset, SCL is released (scl_o = 1), no strobe is raised, and both width registers hold 0xFF.
- R2: Each low phase lasts exactly max(LW,1) consecutive cycles with scl_o = 0, where LW is the low-width register.
- R3: Each high phase lasts max(HW,1) cycles in which scl_sense_i reads 1, where HW is the high-width register. With the sense input following scl_o, that is max(HW,1) cycles of scl_o = 1.
- R4: A write with wr_en_i = 1 loads wr_data_i into the low-width register when wr_sel_i = 0 and into the high-width register when wr_sel_i = 1. A write made while en_i = 1 is ignored.
- R5: sda_upd_o pulses for exactly one cycle in every low phase. The pulse comes H cycles after the first low cycle, which is index 0. H = max(floor(max(LW,1)/4),1), capped at max(LW,1)-1.
- R6: While SCL is released and scl_sense_i reads 0, the high-phase count is frozen and scl_o stays 1.
- R7: When en_i = 1 and run_i = 1 in an idle state, the first low cycle appears after the next clock edge. While run_i stays 1, each low phase follows the previous high phase with no gap.
- R8: After run_i drops, the current low and high phases finish in full, and then scl_o stays 1 with no strobe.
- R9: When en_i = 0, scl_o is 1 and sda_upd_o is 0 in the same cycle. The counters clear, so a later start begins a full-length low phase.
- R10: A width register value of 0 gives a phase of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Interface enable; width writes are accepted only when 0 |
| run_i | input | 1 | Request to generate clock periods |
| wr_en_i | input | 1 | Width register write strobe |
| wr_sel_i | input | 1 | Write target: 0 low width, 1 high width |
| wr_data_i | input | 8 | Width value to write |
| scl_sense_i | input | 1 | Sensed level of the SCL line |
| scl_o | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_upd_o | output | 1 | One-cycle strobe that marks when SDA may change |

## Verification
The low and high widths are driven with a spread of pairs: a mid-range pair, the all-ones reset pair, zero widths, a width of one, and values whose quarter is 0, 1, 5 and 63. These pairs separate an off-by-one in either phase counter, a missing zero-to-one fold, and a wrong shift or clamp for the hold point. Three timed patterns are then applied. A stretched high phase shows whether the count waits for the sensed line. Dropping the request inside a low phase shows that the period completes and clocking then stops. Dropping the enable mid-phase shows that the outputs are gated at once and that the next start runs a full low phase. One more pattern writes the widths while the block is enabled and checks that the old widths are still used.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef enum logic {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } wsel_e;

    localparam int unsigned HOLD_SHIFT = 2;

endpackage

// File: rtl/scl_tg_width_regs.sv
module scl_tg_width_regs
    import scl_tg_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] low_eff_o,
    output logic [W-1:0] high_eff_o
);
    localparam int unsigned NREG = 2;
    localparam logic [W-1:0] RST_VAL = {W{1'b1}};
    localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] raw_q   [NREG];
    logic [W-1:0] eff     [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                raw_q[g] <= RST_VAL;
            end else if (wr_en_i && !en_i && (int'(wr_sel_i) == g)) begin
                raw_q[g] <= wr_data_i;
            end
        end
        // a zero width folds to a single cycle (R10)
        assign eff[g] = (raw_q[g] == '0) ? ONE : raw_q[g];
    end

    assign low_eff_o  = eff[int'(SEL_LOW)];
    assign high_eff_o = eff[int'(SEL_HIGH)];

    p_wr_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        en_i |=> ($stable(raw_q[0]) && $stable(raw_q[1])));

endmodule

// File: rtl/scl_tg_phase_ctrl.sv
module scl_tg_phase_ctrl
    import scl_tg_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         run_i,
    input  logic         scl_sense_i,
    input  logic [W-1:0] low_eff_i,
    input  logic [W-1:0] high_eff_i,
    output phase_e       phase_o,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    phase_e       state_q;
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (run_i) state_q <= PH_LOW;
                end
                PH_LOW: begin
                    if (cnt_q == low_eff_i - ONE) begin
                        state_q <= PH_HIGH;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + ONE;
                    end
                end
                PH_HIGH: begin
                    // count only cycles where the line really reads high
                    if (scl_sense_i) begin
                        if (cnt_q == high_eff_i - ONE) begin
                            state_q <= run_i ? PH_LOW : PH_IDLE;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                end
                default: begin
                    state_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    assign phase_o = state_q;
    assign cnt_o   = cnt_q;

    p_low_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_LOW) |-> (cnt_q < low_eff_i));

    p_high_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_HIGH) |-> (cnt_q < high_eff_i));

    p_stretch_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (en_i && state_q == PH_HIGH && !scl_sense_i)
            |=> (state_q == PH_HIGH && $stable(cnt_q)));

    p_disable_clears_r9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (state_q == PH_IDLE && cnt_q == '0));

endmodule

// File: rtl/scl_tg_hold_strobe.sv
module scl_tg_hold_strobe
    import scl_tg_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  phase_e       phase_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] low_eff_i,
    output logic         strobe_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] quarter;
    logic [W-1:0] hold_pt;

    always_comb begin
        quarter = low_eff_i >> HOLD_SHIFT;
        if (quarter == '0) quarter = ONE;
        // never later than the last low cycle
        hold_pt = (quarter > low_eff_i - ONE) ? (low_eff_i - ONE) : quarter;
    end

    assign strobe_o = en_i && (phase_i == PH_LOW) && (cnt_i == hold_pt);

    p_hold_in_low_r5: assert property (@(posedge clk) disable iff (rst)
        hold_pt < low_eff_i);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_tg_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         run_i,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         scl_sense_i,
    output logic         scl_o,
    output logic         sda_upd_o
);
    logic [W-1:0] low_eff;
    logic [W-1:0] high_eff;
    phase_e       phase;
    logic [W-1:0] cnt;

    scl_tg_width_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .low_eff_o (low_eff),
        .high_eff_o(high_eff)
    );

    scl_tg_phase_ctrl #(.W(W)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .run_i      (run_i),
        .scl_sense_i(scl_sense_i),
        .low_eff_i  (low_eff),
        .high_eff_i (high_eff),
        .phase_o    (phase),
        .cnt_o      (cnt)
    );

    scl_tg_hold_strobe #(.W(W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en_i),
        .phase_i  (phase),
        .cnt_i    (cnt),
        .low_eff_i(low_eff),
        .strobe_o (sda_upd_o)
    );

    assign scl_o = !(en_i && phase == PH_LOW);

    p_strobe_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        sda_upd_o |=> !sda_upd_o);

    p_strobe_while_low_r5: assert property (@(posedge clk) disable iff (rst)
        sda_upd_o |-> !scl_o);

    p_disabled_released_r9: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> (scl_o && !sda_upd_o));

endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       run = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       stretch = 1'b0;
    logic       scl_sense;
    logic       scl;
    logic       sda_upd;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign scl_sense = scl && !stretch;

    scl_timing_gen dut (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en),
        .run_i      (run),
        .wr_en_i    (wr_en),
        .wr_sel_i   (wr_sel),
        .wr_data_i  (wr_data),
        .scl_sense_i(scl_sense),
        .scl_o      (scl),
        .sda_upd_o  (sda_upd)
    );

    // lw, hw, expected low cycles, expected high cycles, expected hold index
    localparam int NVEC = 7;
    localparam int VEC [NVEC][5] = '{
        '{  8,  6,   8,  6,  2},
        '{  0,  0,   1,  1,  0},
        '{  3,  2,   3,  2,  1},
        '{ 20,  5,  20,  5,  5},
        '{255,  1, 255,  1, 63},
        '{  4,  4,   4,  4,  1},
        '{  1,  9,   1,  9,  0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_w(input logic sel, input int val);
        wr_en = 1'b1; wr_sel = sel; wr_data = 8'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // called at a negedge after starting; returns one period's measurements
    task automatic measure(output int lo, output int hi, output int hidx, output int ns);
        int guard = 0;
        lo = 0; hi = 0; hidx = -1; ns = 0;
        @(negedge clk);
        while (scl && guard < 600) begin @(negedge clk); guard++; end
        while (!scl && lo < 600) begin
            if (sda_upd) begin hidx = lo; ns++; end
            lo++;
            @(negedge clk);
        end
        while (scl && hi < 600) begin
            if (sda_upd) ns++;
            hi++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lo, hi, hidx, ns, cnt_hi, bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 scl released after reset", int'(scl), 1);
        check("R1 no strobe after reset", int'(sda_upd), 0);
        en = 1'b1; run = 1'b1;
        measure(lo, hi, hidx, ns);
        check("R1 default low width 0xFF", lo, 255);
        check("R1 default high width 0xFF", hi, 255);
        check("R1 default hold index", hidx, 63);
        en = 1'b0; run = 1'b0;
        @(negedge clk);

        // table of width pairs: R2 R3 R5 R7 R10
        for (int i = 0; i < NVEC; i++) begin
            write_w(1'b0, VEC[i][0]);
            write_w(1'b1, VEC[i][1]);
            en = 1'b1; run = 1'b1;
            measure(lo, hi, hidx, ns);
            check("R2/R10 low phase length", lo, VEC[i][2]);
            check("R3/R10 high phase length", hi, VEC[i][3]);
            check("R5 hold strobe index", hidx, VEC[i][4]);
            check("R5 one strobe per period", ns, 1);
            // R7 back-to-back: scl low again right after the high phase
            check("R7 next low follows high", int'(scl), 0);
            en = 1'b0; run = 1'b0;
            @(negedge clk);
        end

        // R4 writes ignored while enabled
        write_w(1'b0, 10);
        write_w(1'b1, 3);
        en = 1'b1;
        @(negedge clk);
        check("R4 idle while enabled without run", int'(scl), 1);
        write_w(1'b0, 2);
        write_w(1'b1, 7);
        run = 1'b1;
        measure(lo, hi, hidx, ns);
        check("R4 low width write ignored", lo, 10);
        check("R4 high width write ignored", hi, 3);
        en = 1'b0; run = 1'b0;
        @(negedge clk);

        // R6 clock stretching
        write_w(1'b0, 4);
        write_w(1'b1, 3);
        stretch = 1'b1;
        en = 1'b1; run = 1'b1;
        bad = 0;
        @(negedge clk);
        while (scl && bad < 100) begin @(negedge clk); bad++; end
        while (!scl && bad < 200) begin @(negedge clk); bad++; end
        cnt_hi = 0;
        while (scl && cnt_hi < 100) begin
            cnt_hi++;
            if (cnt_hi == 5) stretch = 1'b0;
            @(negedge clk);
        end
        check("R6 stretched high phase length", cnt_hi, 7);
        en = 1'b0; run = 1'b0; stretch = 1'b0;
        @(negedge clk);

        // R8 stop after the current period
        write_w(1'b0, 5);
        write_w(1'b1, 4);
        en = 1'b1; run = 1'b1;
        @(negedge clk);
        check("R7 first low one edge after start", int'(scl), 0);
        run = 1'b0;
        lo = 0;
        while (!scl && lo < 100) begin lo++; @(negedge clk); end
        check("R8 low phase completes after stop", lo, 5);
        cnt_hi = 0; ns = 0;
        for (int k = 0; k < 40; k++) begin
            if (scl) cnt_hi++;
            if (sda_upd) ns++;
            @(negedge clk);
        end
        check("R8 scl stays released after stop", cnt_hi, 40);
        check("R8 no strobe after stop", ns, 0);
        en = 1'b0;
        @(negedge clk);

        // R9 disable mid low phase
        write_w(1'b0, 40);
        write_w(1'b1, 4);
        en = 1'b1; run = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 low before disable", int'(scl), 0);
        en = 1'b0;
        #1;
        check("R9 scl released at once", int'(scl), 1);
        check("R9 strobe suppressed", int'(sda_upd), 0);
        @(negedge clk);
        check("R9 scl stays released", int'(scl), 1);
        en = 1'b1;
        measure(lo, hi, hidx, ns);
        check("R9 full low phase after re-enable", lo, 40);
        check("R9 hold index after re-enable", hidx, 10);
        en = 1'b0; run = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule